// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. The memory is a register array. It is written on the producer's clock edge and read combinationally from the consumer side. Each side keeps its own position counter, which is one bit wider than the memory address. The extra bit records how many times the counter has passed the end of the array.

Each counter is sent to the opposite side as a reflected-binary (Gray) value through two flip-flops, so only one bit of it can change per update. The producer side raises `wr_full` from its own counter and the synchronized reader position. The consumer side raises `rd_empty` from its own counter and the synchronized writer position. Both flags are registered and are computed from the counters' next values.

Top module: `dcfifo_gray`

## Requirements
- R1: The array holds 2^AW words, and each position counter is AW+1 bits wide. AW is at least 2. After reset, `rd_empty` is 1 and `wr_full` is 0.
- R2: Words leave on `rd_data` in the order in which they were accepted.
- R3: `wr_full` rises on the same `wr_clk` edge that stores the 2^AW-th unread word. It falls again once the reads have reached the write side.
- R4: A push while `wr_full` is 1 stores nothing and leaves the write counter unchanged. Draining afterwards yields exactly the 2^AW words that were accepted.
- R5: A pop while `rd_empty` is 1 does not move the read counter. The first word written later is the first word read.
- R6: After a write into an empty FIFO, `rd_empty` stays 1 for at least two `rd_clk` edges, because of the two-flop synchronizer. It falls no later than the fourth edge.
- R7: The Gray form of each counter changes at most one bit per clock of its own domain.
- R8: Several complete fill-and-drain passes wrap both counters. Each pass still sets `wr_full` after exactly 2^AW words and returns the words in order.
- R9: `rd_data` shows the oldest unread word with no extra cycle. Right after a pop edge it already holds the next word.
- R10: Pushes and pops can run at the same time on the two clocks without losing or repeating words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer reset, asynchronous, active low |
| wr_push | input | 1 | Request to store `wr_data` |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No free slot; pushes are ignored |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer reset, asynchronous, active low |
| rd_pop | input | 1 | Request to discard the current head word |
| rd_data | output | DW | Oldest unread word (combinational) |
| rd_empty | output | 1 | No unread word; pops are ignored |

## Verification
The main function is tried with five input patterns:
- **Single word into an empty FIFO.** This measures how many consumer edges pass before the word is visible, which separates a two-flop crossing from a missing or extra stage.
- **Back-to-back fill to capacity, then pushes beyond it.** This separates a full flag that rises on the storing edge from one that is late, and shows whether overflowing pushes are really ignored.
- **Repeated fill-and-drain passes.** These force the wrap bit through both values, which separates correct full detection on the inverted top bits from a plain equality test.
- **Pops on an empty FIFO.** These show whether the read counter can slip ahead of the data.
- **Concurrent streaming on two unrelated clock rates.** This shows that no word is lost or repeated when both flags toggle.

// File: rtl/dcfifo_gray.sv
module dcfifo_gray #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_push,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic [PW-1:0] wbin_nx, wgray_nx, rbin_nx, rgray_nx;
  logic          wr_take, rd_take;

  assign wr_take  = wr_push & ~wr_full;
  assign rd_take  = rd_pop & ~rd_empty;
  assign wbin_nx  = wbin + PW'(wr_take);
  assign rbin_nx  = rbin + PW'(rd_take);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

  always_ff @(posedge wr_clk)
    if (wr_take) mem[wbin[AW-1:0]] <= wr_data;

  assign rd_data = mem[rbin[AW-1:0]];

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      wr_full <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      wr_full <= (wgray_nx == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    end

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) {rq2, rq1} <= '0;
    else           {rq2, rq1} <= {rq1, rgray};

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_empty <= 1'b1;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      rd_empty <= (rgray_nx == wq2);
    end

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) {wq2, wq1} <= '0;
    else           {wq2, wq1} <= {wq1, wgray};
endmodule

module dcfifo_gray_chk #(
  parameter int AW = 4
) (
  input logic        wr_clk,
  input logic        wr_rst_n,
  input logic        rd_clk,
  input logic        rd_rst_n,
  input logic        wr_push,
  input logic        rd_pop,
  input logic        wr_full,
  input logic        rd_empty,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray
);
  // R7
  wgray_one_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R7
  rgray_one_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R4
  push_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && wr_push) |=> $stable(wgray));
  // R5
  pop_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && rd_pop) |=> $stable(rgray));
endmodule

bind dcfifo_gray dcfifo_gray_chk #(.AW(AW)) chk_i (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_push(wr_push), .rd_pop(rd_pop), .wr_full(wr_full), .rd_empty(rd_empty),
  .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_gray_tb_top.sv
module dcfifo_gray_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_push = 0, rd_pop = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic wr_full, rd_empty;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcfifo_gray #(.DW(DW), .AW(AW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_push(wr_push), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_empty(rd_empty));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_push = 1; wr_data = d;
    @(posedge wr_clk); #1;
    wr_push = 0;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge rd_clk);
      if (!rd_empty) begin ok = 1; break; end
    end
  endtask

  task automatic pop_expect(input logic [DW-1:0] exp, input string req);
    bit ok;
    wait_ready(ok);
    chk(ok, req, "word available", int'(ok), 1);
    chk(rd_data == exp, req, "read word", rd_data, exp);
    rd_pop = 1;
    @(posedge rd_clk); #1;
    rd_pop = 0;
  endtask

  task automatic settle();
    repeat (8) @(posedge wr_clk);
    repeat (8) @(posedge rd_clk);
  endtask

  task automatic t_reset();
    #1;
    chk(rd_empty == 1, "R1", "empty in reset", rd_empty, 1);
    chk(wr_full == 0, "R1", "full in reset", wr_full, 0);
  endtask

  task automatic t_empty_pop();
    @(negedge rd_clk); rd_pop = 1;
    repeat (3) @(posedge rd_clk);
    #1; rd_pop = 0;
    chk(rd_empty == 1, "R5", "empty after idle pops", rd_empty, 1);
    push(8'hA5);
    pop_expect(8'hA5, "R5");
    settle();
    chk(rd_empty == 1, "R5", "empty after single word", rd_empty, 1);
  endtask

  task automatic t_latency();
    int n = 0;
    push(8'h3C);
    for (int i = 0; i < 8; i++) begin
      @(posedge rd_clk); #1;
      n++;
      if (!rd_empty) break;
    end
    chk(n >= 2 && n <= 4, "R6", "read edges until not empty", n, 3);
    chk(rd_data == 8'h3C, "R9", "head shown without pop", rd_data, 8'h3C);
    pop_expect(8'h3C, "R6");
    settle();
  endtask

  task automatic fill_drain(input logic [DW-1:0] base, input string req);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH-1) chk(wr_full == 0, "R3", "full before last word", wr_full, 0);
      push(base + DW'(i));
    end
    chk(wr_full == 1, "R3", "full on storing edge", wr_full, 1);
    push(8'hEE); push(8'hEF);
    chk(wr_full == 1, "R4", "full holds after extra pushes", wr_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_expect(base + DW'(i), req);
      if (i < DEPTH-1)
        chk(rd_data == base + DW'(i+1), "R9", "next word right after pop", rd_data, base + DW'(i+1));
    end
    settle();
    chk(rd_empty == 1, "R4", "empty after exactly DEPTH words", rd_empty, 1);
    chk(wr_full == 0, "R3", "full clears after drain", wr_full, 0);
  endtask

  task automatic t_fill();
    fill_drain(8'h10, "R2");
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 3; r++) fill_drain(DW'(8'h40 + r*16), "R8");
  endtask

  task automatic t_stream();
    int errs = 0, got = 0;
    fork
      begin
        int sent = 0;
        while (sent < 40) begin
          @(negedge wr_clk);
          if (!wr_full) begin
            wr_push = 1; wr_data = DW'(sent*7 + 3); sent++;
          end else wr_push = 0;
        end
        @(negedge wr_clk); wr_push = 0;
      end
      begin
        for (int c = 0; c < 2000 && got < 40; c++) begin
          @(negedge rd_clk);
          if (!rd_empty) begin
            if (rd_data != DW'(got*7 + 3)) errs++;
            rd_pop = 1; got++;
          end else rd_pop = 0;
        end
        @(negedge rd_clk); rd_pop = 0;
      end
    join
    chk(got == 40, "R10", "words received", got, 40);
    chk(errs == 0, "R10", "order mismatches", errs, 0);
    settle();
    chk(rd_empty == 1, "R10", "empty after stream", rd_empty, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*3);
    t_reset();
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
    t_empty_pop();
    t_latency();
    t_fill();
    t_wrap();
    t_stream();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule